// File: doc/BRIEF.md
# Memory Test Sequencer and Checker

This block drives a memory controller's local command port as a built-in self-test. Once started, it walks through a fixed suite of test phases. In each memory phase it issues write and read requests (address, write data and byte enables), then compares the returned read data with the pattern it wrote. Two optional phases hold the controller in power-down and then in self-refresh for a programmable number of cycles. The request outputs are a plain request/ready handshake. A request stays on its output until the controller's ready signal is high at a clock edge, and that edge accepts it.

Results are reported four ways. A global pass flag drops on the first mismatch and stays low. A per-lane flag vector follows the most recent read in each byte lane. A one-hot vector shows which phase is running. A single-cycle pulse marks the end of the suite. Read data are matched to reads in issue order. Each phase waits until all of its reads have returned before the next phase begins, so the checker can recompute the expected word from the phase and a running read count instead of storing it.

Top module: `memtest_seq`

## Requirements
- R1: `pass` is 1 after reset and falls in the cycle after a read word with any lane differing from its expected value is accepted on `rdata_valid`. It stays 0 until reset, whatever data arrive later.
- R2: `pass_byte[b]` is 1 after reset. The cycle after each accepted read word, it equals 1 if lane b (bits 8b+7..8b) matched and 0 if it did not. A lane that failed therefore recovers on its next correct word, and lanes that matched are unaffected.
- R3: `test_status` is one-hot while running and zero when idle. The bit meanings are: bit 0 sequential address, bit 1 interleaved write/read, bit 2 byte-mask, bit 3 address-line, bit 4 power-down, bit 5 self-refresh, bit 6 auto-precharge.
- R4: When the last phase ends, `test_done` is 1 for exactly one cycle, and `test_status` is zero in that cycle and afterwards.
- R5: `pd_req` is high only during bit 4, and `sr_req` only during bit 5. Each is high for H consecutive cycles, where H is the `hold_cycles` value at phase entry, or for 1 cycle when that value is 0.
- R6: With `lp_enable` = 0, bits 4 and 5 never appear, and `pd_req` and `sr_req` stay low.
- R7: Phases run in ascending status-bit order with no phase repeated within a run.
- R8: A request is accepted only on an edge where `ready` is high. `wr_req`, `rd_req`, `addr` and `wdata` are held while `ready` is low. A suite issues exactly 5·SEQ_LEN+ADDR_W writes and 4·SEQ_LEN+ADDR_W reads.
- R9: The byte-mask phase first writes a background word with all enables set. It then rewrites each word with lane b enabled only when (b + index) is odd, and expects the disabled lanes to keep the background value. Each of these SEQ_LEN rewrites has at least one enable low.
- R10: The address-line phase writes and reads only the addresses 2^i for i = 0..ADDR_W-1, and each of these carries a distinct data word.
- R11: After `test_done`, a new `start` runs the suite again. The restart does not set a `pass` that has fallen.
- R12: `auto_pc` is high with every request issued during bit 6 and never outside it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begins the suite when idle |
| lp_enable | input | 1 | Enables the power-down and self-refresh phases |
| hold_cycles | input | HOLD_W | Length of each low-power hold in cycles |
| ready | input | 1 | Controller accepts the pending request |
| rdata_valid | input | 1 | Read data word valid |
| rdata | input | 8·BYTES | Read data |
| wr_req | output | 1 | Write request |
| rd_req | output | 1 | Read request |
| addr | output | ADDR_W | Request address |
| wdata | output | 8·BYTES | Write data |
| be | output | BYTES | Byte enables for writes |
| auto_pc | output | 1 | Auto-precharge flag accompanying requests |
| pd_req | output | 1 | Power-down request |
| sr_req | output | 1 | Self-refresh request |
| pass | output | 1 | Sticky overall pass flag |
| pass_byte | output | BYTES | Per-lane pass flags |
| test_status | output | 7 | One-hot running phase |
| test_done | output | 1 | End-of-suite pulse |

## Verification
The bench builds the block with ADDR_W=8, BYTES=2, SEQ_LEN=8 and HOLD_W=8. With these values the walking-one phase reaches every address line, and every masked rewrite leaves one of the two lanes disabled, so the byte-mask phase always exercises masking. Hold lengths of 0, 3 and 5 fit in one byte and keep each run short. The bench runs the suite repeatedly with a random-ready memory model, with and without low-power support. It injects a single-lane read error to check that the sticky flag falls while the per-lane flag recovers, and it checks that a restart leaves the fallen flag low.

// File: rtl/memtest_pkg.sv
package memtest_pkg;

    typedef enum logic [2:0] {
        PH_SEQ  = 3'd0,
        PH_INC  = 3'd1,
        PH_MASK = 3'd2,
        PH_ADDR = 3'd3,
        PH_PD   = 3'd4,
        PH_SR   = 3'd5,
        PH_AP   = 3'd6
    } phase_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WR,
        ST_WR2,
        ST_RD,
        ST_DRAIN,
        ST_HOLD
    } stage_t;

    // Data byte for a given phase, word index, pass (background/foreground) and lane.
    function automatic logic [7:0] pat_byte(phase_t ph, logic [7:0] idx, logic fg, logic [7:0] lane);
        logic [7:0] s;
        s = {idx[5:0], fg, 1'b1};
        return (s * 8'h1D) ^ (lane * 8'h35) ^ ({5'd0, ph} * 8'h4B) ^ 8'hA5;
    endfunction

    // Phase that follows p; low-power phases are skipped when lp is low.
    function automatic phase_t next_phase(phase_t p, logic lp);
        case (p)
            PH_SEQ:  return PH_INC;
            PH_INC:  return PH_MASK;
            PH_MASK: return PH_ADDR;
            PH_ADDR: return lp ? PH_PD : PH_AP;
            PH_PD:   return PH_SR;
            default: return PH_AP;
        endcase
    endfunction

endpackage

// File: rtl/memtest_pattern.sv
module memtest_pattern
    import memtest_pkg::*;
#(
    parameter int ADDR_W  = 8,
    parameter int BYTES   = 2,
    parameter int SEQ_LEN = 8,
    parameter int IDX_W   = 4
) (
    input  phase_t                 phase,
    input  logic [IDX_W-1:0]       idx,
    input  logic                   fg,
    output logic [ADDR_W-1:0]      addr,
    output logic [8*BYTES-1:0]     wdata,
    output logic [BYTES-1:0]       be,
    output logic [8*BYTES-1:0]     exp_data
);
    logic [7:0]       idx8;
    logic [BYTES-1:0] alt;

    assign idx8 = 8'(idx);

    generate
        for (genvar b = 0; b < BYTES; b++) begin : g_lane
            localparam logic ODD = 1'(b % 2);
            logic [7:0] bg_b;
            logic [7:0] fg_b;
            assign alt[b]  = ODD ^ idx[0];
            assign bg_b    = pat_byte(phase, idx8, 1'b0, 8'(b));
            assign fg_b    = pat_byte(phase, idx8, 1'b1, 8'(b));
            assign wdata[8*b +: 8]    = fg ? fg_b : bg_b;
            assign exp_data[8*b +: 8] = (phase == PH_MASK && alt[b]) ? fg_b : bg_b;
        end
    endgenerate

    assign be = fg ? alt : {BYTES{1'b1}};

    always_comb begin
        case (phase)
            PH_ADDR: addr = ADDR_W'(1) << idx;
            PH_INC:  addr = ADDR_W'(SEQ_LEN) + ADDR_W'(idx);
            PH_MASK: addr = ADDR_W'(2 * SEQ_LEN) + ADDR_W'(idx);
            PH_AP:   addr = ADDR_W'(3 * SEQ_LEN) + ADDR_W'(idx);
            default: addr = ADDR_W'(idx);
        endcase
    end
endmodule

// File: rtl/memtest_lanes.sv
module memtest_lanes #(
    parameter int BYTES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 valid,
    input  logic [8*BYTES-1:0]   rdata,
    input  logic [8*BYTES-1:0]   exp_data,
    output logic                 pass,
    output logic [BYTES-1:0]     pass_byte
);
    logic [BYTES-1:0] ok;
    logic             pass_d, pass_q;
    logic [BYTES-1:0] pbyte_d, pbyte_q;

    generate
        for (genvar b = 0; b < BYTES; b++) begin : g_cmp
            assign ok[b] = (rdata[8*b +: 8] == exp_data[8*b +: 8]);
        end
    endgenerate

    always_comb begin
        pass_d  = pass_q;
        pbyte_d = pbyte_q;
        if (valid) begin
            pbyte_d = ok;
            if (!(&ok)) pass_d = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pass_q  <= 1'b1;
            pbyte_q <= {BYTES{1'b1}};
        end else begin
            pass_q  <= pass_d;
            pbyte_q <= pbyte_d;
        end
    end

    assign pass      = pass_q;
    assign pass_byte = pbyte_q;
endmodule

// File: rtl/memtest_seq.sv
module memtest_seq
    import memtest_pkg::*;
#(
    parameter int ADDR_W  = 8,
    parameter int BYTES   = 2,
    parameter int SEQ_LEN = 8,
    parameter int HOLD_W  = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic                 lp_enable,
    input  logic [HOLD_W-1:0]    hold_cycles,
    input  logic                 ready,
    input  logic                 rdata_valid,
    input  logic [8*BYTES-1:0]   rdata,
    output logic                 wr_req,
    output logic                 rd_req,
    output logic [ADDR_W-1:0]    addr,
    output logic [8*BYTES-1:0]   wdata,
    output logic [BYTES-1:0]     be,
    output logic                 auto_pc,
    output logic                 pd_req,
    output logic                 sr_req,
    output logic                 pass,
    output logic [BYTES-1:0]     pass_byte,
    output logic [6:0]           test_status,
    output logic                 test_done
);
    localparam int DATA_W = 8 * BYTES;
    localparam int MAXN   = (ADDR_W > SEQ_LEN) ? ADDR_W : SEQ_LEN;
    localparam int IDX_W  = $clog2(MAXN + 1);

    typedef struct packed {
        stage_t              stage;
        phase_t              phase;
        logic [IDX_W-1:0]    idx;
        logic [IDX_W-1:0]    chk;
        logic [HOLD_W-1:0]   hold;
        logic                done;
    } st_t;

    st_t st_d, st_q;

    logic [IDX_W-1:0]  cnt;
    logic              last;
    logic              advance;
    phase_t            nxt_ph;
    logic [DATA_W-1:0] exp_data;
    logic [DATA_W-1:0] unused_wdata;
    logic [ADDR_W-1:0] unused_addr;
    logic [BYTES-1:0]  unused_be;
    logic [DATA_W-1:0] unused_exp;

    assign cnt  = (st_q.phase == PH_ADDR) ? IDX_W'(ADDR_W) : IDX_W'(SEQ_LEN);
    assign last = (st_q.idx == cnt - IDX_W'(1));

    // Issue side: address, data and enables for the current request.
    memtest_pattern #(
        .ADDR_W(ADDR_W), .BYTES(BYTES), .SEQ_LEN(SEQ_LEN), .IDX_W(IDX_W)
    ) u_issue (
        .phase    (st_q.phase),
        .idx      (st_q.idx),
        .fg       (st_q.stage == ST_WR2),
        .addr     (addr),
        .wdata    (wdata),
        .be       (be),
        .exp_data (unused_exp)
    );

    // Check side: expected word for the next returning read.
    memtest_pattern #(
        .ADDR_W(ADDR_W), .BYTES(BYTES), .SEQ_LEN(SEQ_LEN), .IDX_W(IDX_W)
    ) u_expect (
        .phase    (st_q.phase),
        .idx      (st_q.chk),
        .fg       (1'b0),
        .addr     (unused_addr),
        .wdata    (unused_wdata),
        .be       (unused_be),
        .exp_data (exp_data)
    );

    memtest_lanes #(.BYTES(BYTES)) u_lanes (
        .clk       (clk),
        .rst_n     (rst_n),
        .valid     (rdata_valid),
        .rdata     (rdata),
        .exp_data  (exp_data),
        .pass      (pass),
        .pass_byte (pass_byte)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        advance   = 1'b0;
        nxt_ph    = next_phase(st_q.phase, lp_enable);
        st_d.chk  = st_q.chk + IDX_W'(rdata_valid);

        case (st_q.stage)
            ST_IDLE: begin
                if (start) begin
                    st_d.phase = PH_SEQ;
                    st_d.stage = ST_WR;
                    st_d.idx   = '0;
                    st_d.chk   = '0;
                end
            end
            ST_WR: begin
                if (ready) begin
                    if (st_q.phase == PH_INC) begin
                        st_d.stage = ST_RD;
                    end else if (last) begin
                        st_d.idx   = '0;
                        st_d.stage = (st_q.phase == PH_MASK) ? ST_WR2 : ST_RD;
                    end else begin
                        st_d.idx = st_q.idx + IDX_W'(1);
                    end
                end
            end
            ST_WR2: begin
                if (ready) begin
                    if (last) begin
                        st_d.idx   = '0;
                        st_d.stage = ST_RD;
                    end else begin
                        st_d.idx = st_q.idx + IDX_W'(1);
                    end
                end
            end
            ST_RD: begin
                if (ready) begin
                    if (last) begin
                        st_d.stage = ST_DRAIN;
                    end else begin
                        st_d.idx = st_q.idx + IDX_W'(1);
                        if (st_q.phase == PH_INC) st_d.stage = ST_WR;
                    end
                end
            end
            ST_DRAIN: begin
                if (st_q.chk == cnt) advance = 1'b1;
            end
            ST_HOLD: begin
                if (st_q.hold <= HOLD_W'(1)) advance = 1'b1;
                else st_d.hold = st_q.hold - HOLD_W'(1);
            end
            default: st_d.stage = ST_IDLE;
        endcase

        if (advance) begin
            st_d.idx = '0;
            st_d.chk = '0;
            if (st_q.phase == PH_AP) begin
                st_d.stage = ST_IDLE;
                st_d.done  = 1'b1;
            end else begin
                st_d.phase = nxt_ph;
                if (nxt_ph == PH_PD || nxt_ph == PH_SR) begin
                    st_d.stage = ST_HOLD;
                    st_d.hold  = hold_cycles;
                end else begin
                    st_d.stage = ST_WR;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.stage <= ST_IDLE;
            st_q.phase <= PH_SEQ;
            st_q.idx   <= '0;
            st_q.chk   <= '0;
            st_q.hold  <= '0;
            st_q.done  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign wr_req      = (st_q.stage == ST_WR) || (st_q.stage == ST_WR2);
    assign rd_req      = (st_q.stage == ST_RD);
    assign auto_pc     = (st_q.phase == PH_AP) && (wr_req || rd_req);
    assign pd_req      = (st_q.stage == ST_HOLD) && (st_q.phase == PH_PD);
    assign sr_req      = (st_q.stage == ST_HOLD) && (st_q.phase == PH_SR);
    assign test_status = (st_q.stage == ST_IDLE) ? 7'd0 : (7'd1 << st_q.phase);
    assign test_done   = st_q.done;
endmodule

module memtest_seq_chk #(
    parameter int ADDR_W = 8,
    parameter int BYTES  = 2
) (
    input logic                clk,
    input logic                rst_n,
    input logic                ready,
    input logic                wr_req,
    input logic                rd_req,
    input logic [ADDR_W-1:0]   addr,
    input logic [8*BYTES-1:0]  wdata,
    input logic                auto_pc,
    input logic                pd_req,
    input logic                sr_req,
    input logic                pass,
    input logic [6:0]          test_status,
    input logic                test_done
);
    // R1
    sticky_pass_chk: assert property (@(posedge clk) disable iff (!rst_n) !pass |=> !pass);
    // R3
    status_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(test_status));
    // R4
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) test_done |=> !test_done);
    // R4
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n) test_done |-> (test_status == 7'd0));
    // R5
    pd_phase_chk: assert property (@(posedge clk) disable iff (!rst_n) pd_req |-> (test_status == 7'b0010000));
    // R5
    sr_phase_chk: assert property (@(posedge clk) disable iff (!rst_n) sr_req |-> (test_status == 7'b0100000));
    // R12
    ap_phase_chk: assert property (@(posedge clk) disable iff (!rst_n) auto_pc |-> test_status[6]);
    // R8
    wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && !ready) |=> (wr_req && $stable(addr) && $stable(wdata)));
    // R8
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !ready) |=> (rd_req && $stable(addr)));
endmodule

bind memtest_seq memtest_seq_chk #(.ADDR_W(ADDR_W), .BYTES(BYTES)) u_chk (
    .clk(clk), .rst_n(rst_n), .ready(ready), .wr_req(wr_req), .rd_req(rd_req),
    .addr(addr), .wdata(wdata), .auto_pc(auto_pc), .pd_req(pd_req), .sr_req(sr_req),
    .pass(pass), .test_status(test_status), .test_done(test_done)
);

// File: tb/tb_memtest_seq.sv
module tb_memtest_seq;
    localparam int CLK_NS  = 10;
    localparam int AW      = 8;
    localparam int NB      = 2;
    localparam int SL      = 8;
    localparam int HW      = 8;
    localparam int DW      = 8 * NB;
    localparam int LIMIT   = 150000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic lp_enable = 1'b1;
    logic [HW-1:0] hold_cycles = '0;
    logic ready = 1'b0;
    logic rdata_valid;
    logic [DW-1:0] rdata;
    logic wr_req, rd_req, auto_pc, pd_req, sr_req, pass, test_done;
    logic [AW-1:0] addr;
    logic [DW-1:0] wdata;
    logic [NB-1:0] be, pass_byte;
    logic [6:0] test_status;

    always #(CLK_NS/2) clk = ~clk;

    memtest_seq #(.ADDR_W(AW), .BYTES(NB), .SEQ_LEN(SL), .HOLD_W(HW)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .lp_enable(lp_enable),
        .hold_cycles(hold_cycles), .ready(ready), .rdata_valid(rdata_valid),
        .rdata(rdata), .wr_req(wr_req), .rd_req(rd_req), .addr(addr),
        .wdata(wdata), .be(be), .auto_pc(auto_pc), .pd_req(pd_req),
        .sr_req(sr_req), .pass(pass), .pass_byte(pass_byte),
        .test_status(test_status), .test_done(test_done)
    );

    // Memory model with 3-cycle read latency and single-word error injection.
    logic [DW-1:0] mem [1<<AW];
    logic [2:0]    pv_pipe;
    logic [DW-1:0] pd0, pd1, pd2;
    logic [NB-1:0] rbad;
    logic [NB-1:0] inj_lanes = '0;
    logic [DW-1:0] inj_vec;
    int inj_at = -1;
    int rd_out = 0, wr_cnt = 0, rd_cnt = 0, partial = 0, nonpow = 0;
    int ap_good = 0, ap_bad = 0, ap_miss = 0;
    logic [AW-1:0] addr_or = '0;
    int seen_data [AW];

    always_comb begin
        for (int b = 0; b < NB; b++) inj_vec[8*b +: 8] = inj_lanes[b] ? 8'h01 : 8'h00;
    end

    always @(posedge clk) begin
        if (!rst_n) begin
            pv_pipe     <= '0;
            rdata_valid <= 1'b0;
            rdata       <= '0;
            rbad        <= '0;
        end else begin
            if (wr_req && ready) begin
                for (int b = 0; b < NB; b++)
                    if (be[b]) mem[addr][8*b +: 8] <= wdata[8*b +: 8];
                wr_cnt <= wr_cnt + 1;
                if (test_status[2] && be != '1) partial <= partial + 1;
                if (test_status[3]) begin
                    addr_or <= addr_or | addr;
                    if (addr == 0 || (addr & (addr - 1)) != 0) nonpow <= nonpow + 1;
                    for (int i = 0; i < AW; i++) if (addr == AW'(1) << i) seen_data[i] <= int'(wdata);
                end
            end
            if (rd_req && ready) rd_cnt <= rd_cnt + 1;
            if ((wr_req || rd_req) && ready) begin
                if (test_status[6] && auto_pc) ap_good <= ap_good + 1;
                if (test_status[6] && !auto_pc) ap_miss <= ap_miss + 1;
            end
            if (auto_pc && !test_status[6]) ap_bad <= ap_bad + 1;
            pv_pipe <= {pv_pipe[1:0], rd_req && ready};
            pd0 <= mem[addr];
            pd1 <= pd0;
            pd2 <= pd1;
            rdata_valid <= pv_pipe[2];
            rdata <= pd2;
            rbad  <= '0;
            if (pv_pipe[2]) begin
                rd_out <= rd_out + 1;
                if (rd_out == inj_at) begin
                    rdata <= pd2 ^ inj_vec;
                    rbad  <= inj_lanes;
                end
            end
        end
    end

    // Monitors
    logic          mv = 1'b0;
    logic [NB-1:0] mb = '0;
    always @(posedge clk) begin
        mv <= rst_n && rdata_valid;
        mb <= rbad;
    end

    int lane_cmp = 0, lane_err = 0, lane1_low = 0, pass_late = 0;
    int order_err = 0, hot_err = 0, pd_hi = 0, sr_hi = 0, done_cnt = 0, done_err = 0;
    int bitcyc [7];
    logic [6:0] prev_st = '0;
    logic       prev_done = 1'b0;
    initial for (int i = 0; i < 7; i++) bitcyc[i] = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (mv) begin
                lane_cmp <= lane_cmp + 1;
                if (pass_byte != ~mb) lane_err <= lane_err + 1;
                if (!pass_byte[1]) lane1_low <= lane1_low + 1;
                if (mb != 0 && pass) pass_late <= pass_late + 1;
            end
            for (int i = 0; i < 7; i++) if (test_status[i]) bitcyc[i] <= bitcyc[i] + 1;
            if ($countones(test_status) > 1) hot_err <= hot_err + 1;
            if (test_status != 0 && prev_st != 0 && test_status != prev_st && test_status < prev_st)
                order_err <= order_err + 1;
            if (pd_req) pd_hi <= pd_hi + 1;
            if (sr_req) sr_hi <= sr_hi + 1;
            if (test_done) done_cnt <= done_cnt + 1;
            if (test_done && (prev_done || test_status != 0)) done_err <= done_err + 1;
            prev_st   <= test_status;
            prev_done <= test_done;
        end
    end

    initial begin
        void'($urandom(32'h00C0FFEE));
        forever begin
            @(negedge clk);
            ready = ($urandom % 4) != 0;
        end
    end

    int checks = 0, failures = 0;

    task automatic check(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic run_suite(logic lp, int h, bit exp_pass);
        int w0, r0, p0, n0, ag0, ab0, am0, oe0, he0, pd0s, sr0s, dc0, de0;
        int bc0 [7];
        int hexp;
        int guard;
        w0 = wr_cnt; r0 = rd_cnt; p0 = partial; n0 = nonpow;
        ag0 = ap_good; ab0 = ap_bad; am0 = ap_miss; oe0 = order_err; he0 = hot_err;
        pd0s = pd_hi; sr0s = sr_hi; dc0 = done_cnt; de0 = done_err;
        for (int i = 0; i < 7; i++) bc0[i] = bitcyc[i];
        @(negedge clk);
        lp_enable   = lp;
        hold_cycles = HW'(h);
        start       = 1'b1;
        @(negedge clk);
        start = 1'b0;
        guard = 0;
        while (!test_done && guard < 20000) begin
            @(negedge clk);
            guard++;
        end
        check(test_done == 1'b1, "R4", "done seen", int'(test_done), 1);
        @(negedge clk);
        check(test_done == 1'b0, "R4", "done one cycle", int'(test_done), 0);
        check(test_status == 7'd0, "R4", "status idle after done", int'(test_status), 0);
        repeat (2) @(negedge clk);
        hexp = (h == 0) ? 1 : h;
        check(done_cnt - dc0 == 1 && done_err == de0, "R4", "done pulses", done_cnt - dc0, 1);
        check(wr_cnt - w0 == 5*SL + AW, "R8", "write count", wr_cnt - w0, 5*SL + AW);
        check(rd_cnt - r0 == 4*SL + AW, "R8", "read count", rd_cnt - r0, 4*SL + AW);
        check(order_err == oe0, "R7", "order errors", order_err - oe0, 0);
        check(hot_err == he0, "R3", "one-hot errors", hot_err - he0, 0);
        for (int i = 0; i < 4; i++)
            check(bitcyc[i] > bc0[i], "R3", "phase bit active", i, 1);
        check(bitcyc[6] > bc0[6], "R3", "phase bit 6 active", bitcyc[6] - bc0[6], 1);
        if (lp) begin
            check(pd_hi - pd0s == hexp, "R5", "pd_req cycles", pd_hi - pd0s, hexp);
            check(sr_hi - sr0s == hexp, "R5", "sr_req cycles", sr_hi - sr0s, hexp);
        end else begin
            check(pd_hi == pd0s && sr_hi == sr0s, "R6", "low-power requests", pd_hi - pd0s + sr_hi - sr0s, 0);
            check(bitcyc[4] == bc0[4] && bitcyc[5] == bc0[5], "R6", "low-power bits",
                  bitcyc[4] - bc0[4] + bitcyc[5] - bc0[5], 0);
        end
        check(partial - p0 == SL, "R9", "masked rewrites", partial - p0, SL);
        check(nonpow == n0, "R10", "non walking-one addresses", nonpow - n0, 0);
        check(addr_or == '1, "R10", "address lines covered", int'(addr_or), (1<<AW)-1);
        check(ap_good - ag0 == 2*SL && ap_miss == am0, "R12", "auto-precharge requests", ap_good - ag0, 2*SL);
        check(ap_bad == ab0, "R12", "auto-precharge outside phase", ap_bad - ab0, 0);
        check(pass == exp_pass, "R1", "pass after suite", int'(pass), int'(exp_pass));
        check(pass_byte == '1, "R2", "lanes recovered", int'(pass_byte), (1<<NB)-1);
    endtask

    task automatic run_all();
        int distinct;
        repeat (4) @(negedge clk);
        check(test_status == 7'd0, "R3", "reset status", int'(test_status), 0);
        check(test_done == 1'b0, "R4", "reset done", int'(test_done), 0);
        check(pass == 1'b1, "R1", "reset pass", int'(pass), 1);
        check(pass_byte == '1, "R2", "reset lanes", int'(pass_byte), (1<<NB)-1);
        check(!wr_req && !rd_req && !pd_req && !sr_req, "R8", "reset requests", int'(wr_req | rd_req), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // Clean run with low-power phases
        run_suite(1'b1, 5, 1'b1);
        distinct = 1;
        for (int i = 0; i < AW; i++)
            for (int j = i + 1; j < AW; j++)
                if (seen_data[i] == seen_data[j]) distinct = 0;
        check(distinct == 1, "R10", "distinct walking-one data", distinct, 1);
        check(lane_err == 0 && lane_cmp > 0, "R2", "lane flags clean run", lane_err, 0);

        // Low-power disabled, single-lane error on an early read
        inj_lanes = 2'b10;
        inj_at    = rd_out + 2;
        run_suite(1'b0, 3, 1'b0);
        check(lane_err == 0, "R2", "lane flag follows each word", lane_err, 0);
        check(lane1_low == 1, "R2", "lane 1 low exactly once", lane1_low, 1);
        check(pass_late == 0, "R1", "pass fell with the bad word", pass_late, 0);

        // Restart with zero hold: pass stays low
        inj_at = -1;
        run_suite(1'b1, 0, 1'b0);
        check(pass == 1'b0, "R11", "restart keeps pass low", int'(pass), 0);

        // Another clean run, short hold
        run_suite(1'b1, 3, 1'b0);
        check(lane_err == 0, "R2", "lane flags final", lane_err, 0);
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (LIMIT) @(posedge clk);
                check(1'b0, "R4", "watchdog expired", 0, 1);
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule